// File: doc/BRIEF.md
# Spread Spectrum Pulse Stretcher

This block lengthens the charge phase of every charge-transfer pulse by a varying number of spread-clock periods, so the pulse rate is smeared over a band instead of sitting on one frequency. When the charge phase ends, the pulse sequencer raises a one-cycle request. The stretcher answers with a one-cycle done strobe once the extra delay for that pulse has run out. It then moves its internal sweep position on for the next pulse.

The added delay rises by one spread-clock period per pulse, from zero up to a maximum set by a 7-bit deviation code. It then falls back to zero and repeats. The spread clock is the system clock, or the system clock divided by two. An acquisition-start strobe captures the enable, deviation and prescaler inputs and restarts the sweep at zero, so every acquisition repeats the same sequence of delays.

Top module: `spread_stretch`

## Requirements
- R1: Synchronous active-high reset clears the done output, the sweep position and any delay in progress, and clears the captured enable. Until the next start strobe, a request is answered with no added delay.
- R2: The enable, deviation code and prescaler select are captured only on a cycle with `acq_start` high. Changes to them at any other time have no effect on the delays.
- R3: With the captured enable low, `done` is high in the cycle right after the clock edge that samples `req`.
- R4: With the captured enable high, `done` is high in the cycle after edge t0+N. Here t0 is the edge that samples `req`, and N is the sweep position times P. P is 1 when the prescaler select is 0 and 2 when it is 1.
- R5: With enable high, the sweep position used by successive accepted requests runs 0, 1, …, M, M−1, …, 0, 1, … and repeats, where M = deviation code + 1.
- R6: `acq_start` sets the sweep position to 0 and cancels any delay in progress; no done strobe is produced for the cancelled request. It takes priority over `req` in the same cycle.
- R7: `done` lasts exactly one cycle. A request that arrives while a delay is running, or in the cycle where `done` is high, is ignored: it produces no done strobe and does not move the sweep.
- R8: Deviation code 127 gives a peak of 128 spread periods, which is 256 system clocks with the prescaler select at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Stretch enable, captured on start |
| dev_code | input | 7 | Deviation code; peak stretch is code+1 periods |
| psc_sel | input | 1 | Spread-clock divider: 0 = /1, 1 = /2 |
| acq_start | input | 1 | Start of acquisition: capture settings, restart sweep |
| req | input | 1 | End-of-charge-phase request from the sequencer |
| done | output | 1 | One-cycle strobe when the stretch has elapsed |

## Verification
The embedded properties check the following on every cycle:
- `done` never lasts two cycles.
- A disabled request is answered on the next edge.
- The delay counter falls by exactly one per cycle.
- The sweep position never exceeds the captured peak, and it stays still while a delay is running.
- A start strobe leaves the position at zero with nothing pending.

The exact cycle of each done strobe along a full triangular sweep is only visible from the bench scenarios. The same holds for the doubled period under the divider, the settings that are ignored between starts, the cancelled and reset delays, and the peak at code 127. The bench compares each of these against a triangle model of its own.

// File: rtl/spread_stretch.sv
module spread_stretch #(
  parameter int DEV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DEV_W-1:0] dev_code,
  input  logic             psc_sel,
  input  logic             acq_start,
  input  logic             req,
  output logic             done
);
  localparam int POS_W = DEV_W + 1;
  localparam int CNT_W = DEV_W + 2;

  logic             en_q, psc_q, up_q, busy_q, done_q;
  logic [POS_W-1:0] peak_q, pos_q, pos_nxt;
  logic [CNT_W-1:0] cnt_q, load;
  logic             accept;

  assign accept = req && !busy_q && !done_q && !acq_start;
  assign load   = !en_q ? '0 : (psc_q ? {pos_q, 1'b0} : {1'b0, pos_q});
  assign done   = done_q;

  always_comb begin
    if (up_q) pos_nxt = (pos_q == peak_q) ? pos_q - 1'b1 : pos_q + 1'b1;
    else      pos_nxt = (pos_q == '0)     ? pos_q + 1'b1 : pos_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; psc_q <= 1'b0; peak_q <= '0;
      pos_q <= '0; up_q <= 1'b1;
      busy_q <= 1'b0; cnt_q <= '0; done_q <= 1'b0;
    end else if (acq_start) begin
      en_q <= en; psc_q <= psc_sel; peak_q <= {1'b0, dev_code} + 1'b1;
      pos_q <= '0; up_q <= 1'b1;
      busy_q <= 1'b0; cnt_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (load == '0) done_q <= 1'b1;
        else begin busy_q <= 1'b1; cnt_q <= load; end
        if (en_q) begin
          pos_q <= pos_nxt;
          if (up_q && pos_q == peak_q) up_q <= 1'b0;
          else if (!up_q && pos_q == '0) up_q <= 1'b1;
        end
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin busy_q <= 1'b0; done_q <= 1'b1; end
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !en_q) |=> done_q);
  // R4
  countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q > CNT_W'(1) && !acq_start) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R5
  pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pos_q <= peak_q);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !acq_start) |=> $stable(pos_q));
  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    acq_start |=> (pos_q == '0 && !busy_q && !done_q));
endmodule

// File: tb/test_spread_stretch.sv
module test_spread_stretch;
  logic clk = 0, rst = 1, en = 0, psc_sel = 0, acq_start = 0, req = 0;
  logic [6:0] dev_code = 0;
  logic done;
  int cyc = 0, total = 0, bad = 0;
  int exp_q[$];
  string tag_q[$];
  int m_en = 0, m_M = 1, m_P = 1, m_k = 0;
  bit finished = 0;

  spread_stretch i_spread_stretch (.clk(clk), .rst(rst), .en(en), .dev_code(dev_code),
    .psc_sel(psc_sel), .acq_start(acq_start), .req(req), .done(done));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sweep_at(int k, int M);
    int r;
    r = k % (2 * M);
    return (r <= M) ? r : 2 * M - r;
  endfunction

  task automatic check(bit ok, string rq, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected done", cyc, -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cyc == e, t, cyc, e);
      end
    end
  end

  task automatic start_acq(int e, int d, int p);
    en = e[0]; dev_code = d[6:0]; psc_sel = p[0]; acq_start = 1;
    @(negedge clk);
    acq_start = 0;
    m_en = e; m_M = d + 1; m_P = p ? 2 : 1; m_k = 0;
  endtask

  task automatic pulse(bit spam, string tag);
    int n;
    n = m_en ? sweep_at(m_k, m_M) * m_P : 0;
    if (m_en != 0) m_k++;
    exp_q.push_back(cyc + 1 + n);
    tag_q.push_back(tag);
    req = 1;
    @(negedge clk);
    if (!spam) req = 0;
    repeat (n) @(negedge clk);
    req = 0;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    check(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(done == 0, "R1 reset done low", done, 0);

    start_acq(0, 9, 1);
    for (int i = 0; i < 3; i++) pulse(0, "R3 disabled no stretch");

    start_acq(1, 3, 0);
    for (int i = 0; i < 10; i++) pulse(0, "R5 triangle dev=3");

    start_acq(1, 2, 1);
    for (int i = 0; i < 8; i++) pulse(0, "R4 divided period");

    start_acq(1, 0, 0);
    for (int i = 0; i < 4; i++) pulse(0, "R5 dev=0 sweep");

    start_acq(1, 1, 0);
    en = 0; dev_code = 6; psc_sel = 1;
    for (int i = 0; i < 5; i++) pulse(0, "R2 settings held");

    start_acq(1, 4, 0);
    for (int i = 0; i < 3; i++) pulse(0, "R5 before spam");
    pulse(1, "R7 busy requests ignored");
    pulse(0, "R7 sweep not moved by ignored");

    // R6: cancel a running delay (position 3, N=3)
    start_acq(1, 4, 0);
    for (int i = 0; i < 3; i++) pulse(0, "R6 before cancel");
    req = 1;
    @(negedge clk);
    req = 0;
    start_acq(1, 4, 0);
    repeat (5) begin
      check(done == 0, "R6 cancelled no done", done, 0);
      @(negedge clk);
    end
    pulse(0, "R6 restart at zero");
    pulse(0, "R6 restart step one");

    // R1: reset during a delay
    start_acq(1, 5, 0);
    for (int i = 0; i < 4; i++) pulse(0, "R1 before reset");
    req = 1;
    @(negedge clk);
    req = 0;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    m_en = 0;
    repeat (6) begin
      check(done == 0, "R1 delay cleared", done, 0);
      @(negedge clk);
    end
    pulse(0, "R1 enable cleared by reset");
    start_acq(1, 5, 0);
    pulse(0, "R1 sweep from zero");
    pulse(0, "R1 sweep step");

    start_acq(1, 127, 1);
    for (int i = 0; i < 131; i++) pulse(0, "R8 peak 128 periods");

    check(exp_q.size() == 0, "R7 missing done", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule